// File: doc/BRIEF.md
# Streaming DRAM Command Sequencer

This block sits on the memory-module side of a serial command link. Each command arrives as one word-parallel packet naming a bank, a row, a column and a burst length. The block captures the packet and drives a 25-bit address/control bus shared by every DRAM device on the module. It then walks the row-to-column and column-to-data delays itself and marks each 64-bit read word as it returns from the devices, which all work in parallel.

Because the command fields come over the link and not on dedicated pins, they are held in registers for the whole access. The per-bank open-row state is remembered. A packet that hits the open row skips activation. A packet for a different row in an open bank is preceded by a precharge. One packet can stream up to 256 words. While an access is in flight the block drops its ready output, so a sender holding a packet simply waits.

Top module: `odram_cmd_seq`

## Requirements
- R1: During and directly after synchronous reset, `pkt_ready` is 1, `dram_cmd` is all zero, and `rd_valid` and `done` are 0. Every bank starts closed.
- R2: A packet is taken only on a clock edge where `pkt_valid` and `pkt_ready` are both 1. `pkt_ready` stays 0 from the cycle after that edge through the `done` cycle. A packet offered while the block is busy is not lost: it is taken once ready returns.
- R3: For a packet to a closed bank, the first cycle after acceptance carries an activate. The bus then holds opcode 3'b001 in bits [24:22], the bank in bits [21:19], zeros in [18:16] and the row in [15:0].
- R4: The read command comes exactly TRCD cycles after the activate. It carries opcode 3'b010 in [24:22], the bank in [21:19], and the column zero-extended in [15:0].
- R5: The first data word is marked valid exactly TCL cycles after the read command. Then `burst` field + 1 consecutive words are marked valid. On each of them `rd_data` equals `dram_rdata`; outside them `rd_data` is zero.
- R6: `done` is high for exactly one cycle, the cycle after the last data word.
- R7: A packet whose bank is open on the same row issues its read command in the first cycle after acceptance, with no activate.
- R8: A packet whose bank is open on a different row first issues a precharge in the first cycle after acceptance: opcode 3'b011 in [24:22] with the bank in [21:19]. The activate for the new row follows exactly TRP cycles later.
- R9: In every cycle that carries no activate, read or precharge, `dram_cmd` is all zero.
- R10: The bank, row and column on the bus, and the number of words, are those captured at acceptance. Changes on the packet inputs during the access have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Packet present on the packet inputs |
| pkt_bank | input | 3 | Target bank |
| pkt_burst | input | 8 | Words in the burst minus one |
| pkt_row | input | 16 | Row address |
| pkt_col | input | 10 | Column address |
| pkt_ready | output | 1 | Block idle and able to take a packet |
| dram_cmd | output | 25 | Address/control bus to the DRAM devices |
| dram_rdata | input | 64 | Read data from the DRAM devices |
| rd_data | output | 64 | Read data forwarded during valid words, else zero |
| rd_valid | output | 1 | Current `rd_data` word belongs to the burst |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The bench drives packets back to back so that each one is held against a busy block with different field values. A sequencer that took a packet early, or that read live inputs instead of captured ones, would then put the wrong bank or row on the bus. The sequence walks a bank through closed, same-row, different-row and reopened states. This exposes a missing precharge, a needless activate on a row hit, or a precharge-to-activate gap off by one. A 256-word burst and single-word bursts catch a word counter that drops or adds a word, and so catch a `done` pulse in the wrong cycle. The all-ones row and the largest column catch any field that is truncated or shifted on the bus.

// File: rtl/odram_pkg.sv
// Shared types for the streaming DRAM command sequencer.
// Assumes a 3-bit opcode at the top of the address/control bus.
package odram_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_NOP = 3'b000;
    localparam logic [OP_W-1:0] OP_ACT = 3'b001;
    localparam logic [OP_W-1:0] OP_RD  = 3'b010;
    localparam logic [OP_W-1:0] OP_PRE = 3'b011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_ACT,
        ST_WAIT_RCD,
        ST_COL,
        ST_WAIT_CL,
        ST_BURST,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/odram_downctr.sv
// Loadable down-counter that stops at zero.
// Used both for the command-to-command delays and for counting data words.
// Assumes load has priority over decrement.
module odram_downctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);

    // Counter register: load, else step down toward zero.
    always_ff @(posedge clk) begin : p_cnt
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/odram_bank_table.sv
// Open-row table: one open flag and one row register per bank.
// A bank is marked open with its row when an activate is issued.
// Lookup is combinational, so the caller reads it in the acceptance cycle.
module odram_bank_table #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_open,
    output logic              lk_hit
);

    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    // Table update: clear on reset, record bank and row on activate.
    always_ff @(posedge clk) begin : p_table
        if (!rst_n) begin
            open_q <= '0;
            for (int b = 0; b < NBANK; b++) begin
                row_q[b] <= '0;
            end
        end else if (wr_en) begin
            open_q[wr_bank] <= 1'b1;
            row_q[wr_bank]  <= wr_row;
        end
    end

    assign lk_open = open_q[lk_bank];
    assign lk_hit  = lk_open && (row_q[lk_bank] == lk_row);

endmodule

// File: rtl/odram_cmd_seq.sv
// Streaming DRAM command sequencer (top).
// Captures a packet (bank, burst, row, column), then issues precharge,
// activate and read on a shared address/control bus with TRP, TRCD and TCL
// spacing. It then marks burst+1 returning data words and pulses done.
// Assumes every delay parameter is at least 2 cycles.
module odram_cmd_seq #(
    parameter int BANK_W  = 3,
    parameter int BLEN_W  = 8,
    parameter int ROW_W   = 16,
    parameter int COL_W   = 10,
    parameter int DATA_W  = 64,
    parameter int CMD_W   = 25,
    parameter int TRCD    = 10,
    parameter int TCL     = 10,
    parameter int TRP     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [BANK_W-1:0] pkt_bank,
    input  logic [BLEN_W-1:0] pkt_burst,
    input  logic [ROW_W-1:0]  pkt_row,
    input  logic [COL_W-1:0]  pkt_col,
    output logic              pkt_ready,
    output logic [CMD_W-1:0]  dram_cmd,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done
);
    import odram_pkg::*;

    localparam int OP_LSB   = CMD_W - OP_W;
    localparam int BANK_LSB = OP_LSB - BANK_W;
    localparam int T_MAX    = (TRCD > TCL) ? ((TRCD > TRP) ? TRCD : TRP)
                                           : ((TCL > TRP) ? TCL : TRP);
    localparam int TMR_W    = $clog2(T_MAX) + 1;
    localparam int COL_PAD  = ROW_W - COL_W;

    seq_state_t        state_q, state_d;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    logic              accept;
    logic              lk_open, lk_hit;
    logic              tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0]  tmr_val, tmr_cnt;
    logic [BLEN_W-1:0] beat_cnt;
    logic              beat_zero;

    assign accept = (state_q == ST_IDLE) && pkt_valid;

    odram_bank_table #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (state_q == ST_ACT),
        .wr_bank (bank_q),
        .wr_row  (row_q),
        .lk_bank (pkt_bank),
        .lk_row  (pkt_row),
        .lk_open (lk_open),
        .lk_hit  (lk_hit)
    );

    odram_downctr #(.W(TMR_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .cnt      (tmr_cnt),
        .zero     (tmr_zero)
    );

    odram_downctr #(.W(BLEN_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (pkt_burst),
        .dec      (state_q == ST_BURST),
        .cnt      (beat_cnt),
        .zero     (beat_zero)
    );

    // Capture the packet fields at acceptance and hold them for the access.
    always_ff @(posedge clk) begin : p_capture
        if (!rst_n) begin
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
        end else if (accept) begin
            bank_q <= pkt_bank;
            row_q  <= pkt_row;
            col_q  <= pkt_col;
        end
    end

    // Delay timer control: load on each command, count down in wait states.
    always_comb begin : p_timer_ctl
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PRE: begin tmr_load = 1'b1; tmr_val = TMR_W'(TRP - 2);  end
            ST_ACT: begin tmr_load = 1'b1; tmr_val = TMR_W'(TRCD - 2); end
            ST_COL: begin tmr_load = 1'b1; tmr_val = TMR_W'(TCL - 2);  end
            default: ;
        endcase
        tmr_dec = (state_q == ST_WAIT_RP) || (state_q == ST_WAIT_RCD) ||
                  (state_q == ST_WAIT_CL);
    end

    // Next-state logic of the access sequence.
    always_comb begin : p_next
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = lk_hit  ? ST_COL :
                                               lk_open ? ST_PRE : ST_ACT;
            ST_PRE:      state_d = ST_WAIT_RP;
            ST_WAIT_RP:  if (tmr_zero) state_d = ST_ACT;
            ST_ACT:      state_d = ST_WAIT_RCD;
            ST_WAIT_RCD: if (tmr_zero) state_d = ST_COL;
            ST_COL:      state_d = ST_WAIT_CL;
            ST_WAIT_CL:  if (tmr_zero) state_d = ST_BURST;
            ST_BURST:    if (beat_zero) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin : p_state
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address/control bus: opcode, bank and address from captured fields.
    always_comb begin : p_cmd
        dram_cmd = '0;
        unique case (state_q)
            ST_PRE: begin
                dram_cmd[OP_LSB +: OP_W]     = OP_PRE;
                dram_cmd[BANK_LSB +: BANK_W] = bank_q;
            end
            ST_ACT: begin
                dram_cmd[OP_LSB +: OP_W]     = OP_ACT;
                dram_cmd[BANK_LSB +: BANK_W] = bank_q;
                dram_cmd[ROW_W-1:0]          = row_q;
            end
            ST_COL: begin
                dram_cmd[OP_LSB +: OP_W]     = OP_RD;
                dram_cmd[BANK_LSB +: BANK_W] = bank_q;
                dram_cmd[ROW_W-1:0]          = {{COL_PAD{1'b0}}, col_q};
            end
            default: ;
        endcase
    end

    assign pkt_ready = (state_q == ST_IDLE);
    assign rd_valid  = (state_q == ST_BURST);
    assign rd_data   = rd_valid ? dram_rdata : '0;
    assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/odram_cmd_seq_chk.sv
// Timing checker for the command sequencer, bound into every instance.
// Measures gaps between bus commands with its own counters.
module odram_cmd_seq_chk #(
    parameter int CMD_W = 25,
    parameter int TRCD  = 10,
    parameter int TCL   = 10,
    parameter int TRP   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [CMD_W-1:0] dram_cmd,
    input logic             rd_valid,
    input logic             done
);
    import odram_pkg::*;

    logic [OP_W-1:0] op;
    logic [15:0]     since_act, since_pre, since_rd;
    logic            act_seen, pre_seen;

    assign op = dram_cmd[CMD_W-1 -: OP_W];

    // Cycles since the last activate, precharge and read command.
    always_ff @(posedge clk) begin : p_gaps
        if (!rst_n) begin
            since_act <= '0;
            since_pre <= '0;
            since_rd  <= '0;
            act_seen  <= 1'b0;
            pre_seen  <= 1'b0;
        end else begin
            if (op == OP_ACT)           since_act <= 16'd1;
            else if (since_act != '1)   since_act <= since_act + 16'd1;
            if (op == OP_PRE)           since_pre <= 16'd1;
            else if (since_pre != '1)   since_pre <= since_pre + 16'd1;
            if (op == OP_RD)            since_rd  <= 16'd1;
            else if (since_rd != '1)    since_rd  <= since_rd + 16'd1;
            if (pkt_valid && pkt_ready) begin
                act_seen <= 1'b0;
                pre_seen <= 1'b0;
            end else begin
                if (op == OP_ACT) act_seen <= 1'b1;
                if (op == OP_PRE) pre_seen <= 1'b1;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (pkt_ready && (dram_cmd == '0) && !rd_valid && !done)); // R1
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> !pkt_ready); // R2
    AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_RD) && act_seen) |-> (since_act == 16'(TRCD))); // R4
    AST_CL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (since_rd == 16'(TCL))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_ACT) && pre_seen) |-> (since_pre == 16'(TRP))); // R8
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (dram_cmd == '0)); // R9

endmodule

bind odram_cmd_seq odram_cmd_seq_chk #(
    .CMD_W (CMD_W),
    .TRCD  (TRCD),
    .TCL   (TCL),
    .TRP   (TRP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .dram_cmd  (dram_cmd),
    .rd_valid  (rd_valid),
    .done      (done)
);

// File: tb/test_odram_cmd_seq.sv
// Bench: behavioural reference schedule compared on every clock.
module test_odram_cmd_seq;

    localparam int TRCD = 10;
    localparam int TCL  = 10;
    localparam int TRP  = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pkt_valid;
    logic [2:0]  pkt_bank;
    logic [7:0]  pkt_burst;
    logic [15:0] pkt_row;
    logic [9:0]  pkt_col;
    logic        pkt_ready;
    logic [24:0] dram_cmd;
    logic [63:0] dram_rdata;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic        done;

    always #5 clk = ~clk;

    odram_cmd_seq i_odram_cmd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_valid  (pkt_valid),
        .pkt_bank   (pkt_bank),
        .pkt_burst  (pkt_burst),
        .pkt_row    (pkt_row),
        .pkt_col    (pkt_col),
        .pkt_ready  (pkt_ready),
        .dram_cmd   (dram_cmd),
        .dram_rdata (dram_rdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .done       (done)
    );

    typedef struct {
        logic [24:0] cmd;
        bit          vld;
        bit          dn;
        string       tag;
    } exp_t;

    typedef struct {
        int bank;
        int blen;
        int row;
        int col;
        int gap;
    } pkt_t;

    exp_t  sched[$];
    pkt_t  stim[$];
    bit    open_b[8];
    int    row_b[8];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    finished = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [24:0] mk(logic [2:0] op, int bank, int addr);
        return {op, 3'(bank), 3'b000, 16'(addr)};
    endfunction

    function automatic void add(logic [24:0] c, bit v, bit d, string t);
        exp_t e;
        e.cmd = c; e.vld = v; e.dn = d; e.tag = t;
        sched.push_back(e);
    endfunction

    // Expected cycle-by-cycle schedule for one accepted packet.
    function automatic void plan(pkt_t p);
        if (open_b[p.bank] && row_b[p.bank] == p.row) begin
            add(mk(3'b010, p.bank, p.col), 0, 0, "R7 row-hit read");
        end else begin
            if (open_b[p.bank]) begin
                add(mk(3'b011, p.bank, 0), 0, 0, "R8 precharge");
                for (int i = 0; i < TRP - 1; i++) add('0, 0, 0, "R8 R9 rp gap");
                add(mk(3'b001, p.bank, p.row), 0, 0, "R8 activate after rp");
            end else begin
                add(mk(3'b001, p.bank, p.row), 0, 0, "R3 R10 activate");
            end
            for (int i = 0; i < TRCD - 1; i++) add('0, 0, 0, "R4 R9 rcd gap");
            add(mk(3'b010, p.bank, p.col), 0, 0, "R4 R10 read");
            open_b[p.bank] = 1;
            row_b[p.bank]  = p.row;
        end
        for (int i = 0; i < TCL - 1; i++) add('0, 0, 0, "R5 R9 cl gap");
        for (int i = 0; i <= p.blen; i++) add('0, 1, 0, "R5 R10 data word");
        add('0, 0, 1, "R6 done");
    endfunction

    function automatic pkt_t pk(int b, int l, int r, int c, int g);
        pkt_t p;
        p.bank = b; p.blen = l; p.row = r; p.col = c; p.gap = g;
        return p;
    endfunction

    initial begin : main
        exp_t        e;
        bit          cur_ready;
        int          idle_left;
        logic [63:0] rdrv;
        rst_n = 1'b0; pkt_valid = 1'b0; pkt_bank = '0; pkt_burst = '0;
        pkt_row = '0; pkt_col = '0; dram_rdata = '0; rdrv = '0;
        repeat (2) @(negedge clk);
        // R1: state held in reset
        chk("R1 ready", 64'(pkt_ready), 64'd1);
        chk("R1 cmd", 64'(dram_cmd), 64'd0);
        chk("R1 valid", 64'(rd_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        rst_n = 1'b1;

        stim.push_back(pk(0, 3, 5, 8, 0));          // closed bank
        stim.push_back(pk(0, 0, 5, 16, 0));         // row hit, back to back
        stim.push_back(pk(0, 1, 9, 4, 3));          // row miss after a gap
        stim.push_back(pk(3, 255, 9, 1023, 0));     // longest burst
        stim.push_back(pk(3, 2, 9, 2, 0));          // row hit
        stim.push_back(pk(7, 0, 65535, 0, 2));      // extreme fields
        stim.push_back(pk(0, 0, 5, 3, 0));          // miss back to first row

        idle_left = 10;
        while (idle_left > 0) begin
            @(negedge clk);
            if (sched.size() > 0) begin
                e = sched.pop_front();
                cur_ready = 0;
            end else begin
                e.cmd = '0; e.vld = 0; e.dn = 0; e.tag = "R9 idle";
                cur_ready = 1;
            end
            chk("R2 ready", 64'(pkt_ready), 64'(cur_ready));
            chk(e.tag, 64'(dram_cmd), 64'(e.cmd));
            chk("R5 valid", 64'(rd_valid), 64'(e.vld));
            chk("R6 done", 64'(done), 64'(e.dn));
            chk("R5 data", rd_data, e.vld ? rdrv : 64'd0);

            rdrv = {$urandom(), $urandom()};
            dram_rdata = rdrv;
            if (stim.size() > 0 && stim[0].gap == 0) begin
                pkt_valid = 1'b1;
                pkt_bank  = 3'(stim[0].bank);
                pkt_burst = 8'(stim[0].blen);
                pkt_row   = 16'(stim[0].row);
                pkt_col   = 10'(stim[0].col);
                if (cur_ready) plan(stim.pop_front());
            end else begin
                if (stim.size() > 0 && cur_ready) stim[0].gap--;
                pkt_valid = 1'b0;
                pkt_bank  = 3'($urandom());
                pkt_burst = 8'($urandom());
                pkt_row   = 16'($urandom());
                pkt_col   = 10'($urandom());
            end
            if (stim.size() == 0 && sched.size() == 0) idle_left--;
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule